// File: doc/BRIEF.md
# Pin Change-Detect Interrupt Unit

The unit watches eight general-purpose input pins, grouped as two ports of four, and raises a per-pin interrupt flag whenever the synchronized level of a pin disagrees with a reference bit held for that pin. Each pin passes through a two-flop synchronizer. The flag is a registered comparison of the synchronized level against the reference. The eight flags are ORed and registered onto a single interrupt request line.

Software acknowledges a pin by writing its new reference level, not by clearing a status bit. A set command moves the reference to 1 and a clear command moves it to 0. After the acknowledgement the reference shows the level the pin has settled at. While the flag is up, the reference shows which way the pin moved. All state is reached through one 32-bit word with a write enable, write data and combinational read data. In each byte-wide field the low nibble belongs to port 0 and the high nibble to port 1.

Top module: `gpio_change_irq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every flag, every reference bit and `irq_o` read 0.
- R2: Read word layout: bits [7:0] hold the flags, bits [15:8] hold the reference bits, and bit i of each field is pin i (pins 0-3 are port 0, pins 4-7 are port 1). Bits [31:16] always read 0.
- R3: A pin's flag is the registered inequality of its synchronized level and its reference. A level change on `pin_i` appears in the flag at the third rising clock edge.
- R4: Writing 1 to bit 16+i with `we_i` high sets reference bit i to 1 at that edge.
- R5: Writing 1 to bit 24+i with `we_i` high, and bit 16+i low, clears reference bit i to 0 at that edge.
- R6: The flag uses the reference value written at the same edge. The flag therefore drops at the write edge when the new reference equals the synchronized pin, and it rises or stays up when they differ.
- R7: A raised flag with reference 0 means a low-to-high change. A raised flag with reference 1 means a high-to-low change.
- R8: Command bits written as 0, bits [15:0] of any write, and cycles with `we_i` low all leave the reference bits unchanged.
- R9: When one write sets both the set bit and the clear bit of the same pin, the reference becomes 1.
- R10: `irq_o` equals the OR of the eight flags as they stood one clock earlier.
- R11: When a pin change and a command write arrive in the same cycle, the write updates the reference at once. The flag compares the new reference with the synchronized level, which still holds the pre-change value until the synchronizer catches up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous pin levels; bits 3:0 are port 0 and bits 7:4 are port 1 |
| we_i | input | 1 | Write strobe for the command fields |
| wdata_i | input | 32 | Write data: set commands in [23:16], clear commands in [31:24] |
| rdata_o | output | 32 | Read word: flags, reference bits, zeros |
| irq_o | output | 1 | Registered OR of all flags |

## Verification
The risky overlap is a pin edge travelling through the synchronizer while software writes a set or clear command for the same pin. In that case the reference update and the flag comparison land on the same clock edge. The bench provokes this directly, by changing a pin and issuing its command in one cycle, and also at random over a long run of toggling pins and mixed writes. It judges every cycle against a behavioural model. In that model a queue stands in for the synchronizer delay and the new reference is applied before the comparison.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Byte-wide fields of the register word, in bit order.
  typedef enum int unsigned {
    FLD_STATE = 0,
    FLD_REF   = 1,
    FLD_SET   = 2,
    FLD_CLR   = 3
  } field_e;

  localparam int unsigned NUM_FIELDS = 4;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_ref_bank.sv
module gpio_irq_ref_bank #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] set_cmd_i,
  input  logic [NUM_PINS-1:0] clr_cmd_i,
  output logic [NUM_PINS-1:0] ref_d_o,
  output logic [NUM_PINS-1:0] ref_q_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // Set has priority over clear.
    always_comb begin
      ref_d_o[i] = ref_q_o[i];
      if (we_i && set_cmd_i[i])      ref_d_o[i] = 1'b1;
      else if (we_i && clr_cmd_i[i]) ref_d_o[i] = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ref_q_o[i] <= 1'b0;
      else         ref_q_o[i] <= ref_d_o[i];
    end

    AST_SET_FORCES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && set_cmd_i[i]) |=> ref_q_o[i]); // R4
    AST_CLR_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && clr_cmd_i[i] && !set_cmd_i[i]) |=> !ref_q_o[i]); // R5
    AST_REF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && (set_cmd_i[i] || clr_cmd_i[i])) |=> $stable(ref_q_o[i])); // R8
  end
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] ref_d_i,
  output logic [NUM_PINS-1:0] flag_q_o,
  output logic                irq_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q_o <= '0;
      irq_q_o  <= 1'b0;
    end else begin
      flag_q_o <= level_i ^ ref_d_i;
      irq_q_o  <= |flag_q_o;
    end
  end

  AST_IRQ_IS_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_q_o == $past(|flag_q_o))); // R10
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W     = NUM_FIELDS * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int unsigned OFS_STATE = FLD_STATE * NUM_PINS;
  localparam int unsigned OFS_REF   = FLD_REF   * NUM_PINS;
  localparam int unsigned OFS_SET   = FLD_SET   * NUM_PINS;
  localparam int unsigned OFS_CLR   = FLD_CLR   * NUM_PINS;

  logic [NUM_PINS-1:0] level_sync;
  logic [NUM_PINS-1:0] ref_d, ref_q;
  logic [NUM_PINS-1:0] flag_q;
  logic                unused_low_wdata;

  assign unused_low_wdata = ^wdata_i[OFS_SET-1:0];

  gpio_irq_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (level_sync)
  );

  gpio_irq_ref_bank #(
    .NUM_PINS (NUM_PINS)
  ) i_ref_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .set_cmd_i (wdata_i[OFS_SET +: NUM_PINS]),
    .clr_cmd_i (wdata_i[OFS_CLR +: NUM_PINS]),
    .ref_d_o   (ref_d),
    .ref_q_o   (ref_q)
  );

  gpio_irq_flags #(
    .NUM_PINS (NUM_PINS)
  ) i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level_sync),
    .ref_d_i  (ref_d),
    .flag_q_o (flag_q),
    .irq_q_o  (irq_o)
  );

  always_comb begin
    rdata_o                          = '0;
    rdata_o[OFS_STATE +: NUM_PINS]   = flag_q;
    rdata_o[OFS_REF   +: NUM_PINS]   = ref_q;
  end

  AST_FLAG_TRACKS_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flag_q == ($past(level_sync) ^ ref_q))); // R3
  AST_CMD_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && |wdata_i[OFS_SET +: NUM_PINS] && ((wdata_i[OFS_SET +: NUM_PINS] & ~level_sync) == '0))
    |=> ((flag_q & $past(wdata_i[OFS_SET +: NUM_PINS])) == '0)); // R6
endmodule

// File: tb/test_gpio_change_irq.sv
module test_gpio_change_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_change_irq i_gpio_change_irq (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .pin_i   (pin),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  // Behavioural reference model
  logic [7:0] pipe[$];
  logic [7:0] m_ref, m_flag;
  logic       m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = {8'h00, 8'h00};
      m_ref = '0; m_flag = '0; m_irq = 1'b0;
    end else begin
      logic [7:0] nref;
      logic [7:0] synced;
      synced = pipe[0];
      nref = m_ref;
      if (we) begin
        for (int i = 0; i < 8; i++) begin
          if (wdata[16+i])      nref[i] = 1'b1;
          else if (wdata[24+i]) nref[i] = 1'b0;
        end
      end
      m_irq  = (m_flag != 0);
      m_flag = synced ^ nref;
      m_ref  = nref;
      void'(pipe.pop_front());
      pipe.push_back(pin);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    chk("R3 flags", {24'h0, rdata[7:0]}, {24'h0, m_flag});
    chk("R4 ref", {24'h0, rdata[15:8]}, {24'h0, m_ref});
    chk("R2 cmd readback", {16'h0, rdata[31:16]}, 32'h0);
    chk("R10 irq", {31'h0, irq}, {31'h0, m_irq});
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk); pin = p;
  endtask

  initial begin
    step(3);
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle", rdata, 32'h0);

    set_pins(8'h05); step(5);
    chk("R3 flags after rise", {24'h0, rdata[7:0]}, 32'h05);
    chk("R7 rising ref low", {24'h0, rdata[15:8]}, 32'h00);
    chk("R10 irq up", {31'h0, irq}, 32'h1);

    wr(32'h0005_0000);
    chk("R4 set ref", {24'h0, rdata[15:8]}, 32'h05);
    chk("R6 ack clears", {24'h0, rdata[7:0]}, 32'h00);
    step(2);
    chk("R10 irq down", {31'h0, irq}, 32'h0);

    set_pins(8'h04); step(5);
    chk("R7 falling flag", {24'h0, rdata[7:0]}, 32'h01);
    chk("R7 falling ref high", {24'h0, rdata[15:8]}, 32'h05);

    wr(32'h0100_0000);
    chk("R5 clr ref", {24'h0, rdata[15:8]}, 32'h04);
    chk("R6 ack clears fall", {24'h0, rdata[7:0]}, 32'h00);

    wr(32'h0000_FFFF);
    chk("R8 no effect ref", {24'h0, rdata[15:8]}, 32'h04);
    chk("R8 no effect flags", {24'h0, rdata[7:0]}, 32'h00);
    chk("R2 upper zero", {16'h0, rdata[31:16]}, 32'h0);

    set_pins(8'h84); step(5);
    chk("R2 port1 pin3 bit7", {24'h0, rdata[7:0]}, 32'h80);
    wr(32'h8080_0000);
    chk("R9 set wins ref", {24'h0, rdata[15:8]}, 32'h84);
    chk("R9 set wins flags", {24'h0, rdata[7:0]}, 32'h00);

    wr(32'h0002_0000);
    chk("R6 mismatch raises", {24'h0, rdata[7:0]}, 32'h02);
    wr(32'h0200_0000);
    chk("R6 back to match", {24'h0, rdata[7:0]}, 32'h00);

    // Pin change and acknowledgement in the same cycle
    @(negedge clk); pin = 8'h04; we = 1'b1; wdata = 32'h8000_0000;
    @(negedge clk); we = 1'b0; wdata = '0;
    chk("R11 ref updated", {24'h0, rdata[15:8]}, 32'h04);
    chk("R11 flag from stale level", {24'h0, rdata[7:0]}, 32'h80);
    step(2);
    chk("R11 flag settles", {24'h0, rdata[7:0]}, 32'h00);

    // Mixed random traffic, judged by the per-cycle model
    begin
      logic [31:0] lfsr = 32'hACE1_2345;
      for (int k = 0; k < 4000; k++) begin
        @(negedge clk);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (lfsr[3:0] == 4'h0) pin = lfsr[15:8];
        we = (lfsr[6:4] == 3'b101);
        wdata = {lfsr[31:16], lfsr[7:0], lfsr[23:16]};
      end
      @(negedge clk); we = 1'b0; wdata = '0;
    end
    step(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_checks++; n_fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected<150000 cycles", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule